// File: doc/BRIEF.md
# I2C Register Target with Interrupt Output

This block is an I2C target that gives a host read and write access to a small bank of 8-bit control registers. It sits behind a fixed 7-bit bus address. Both bus lines are oversampled with the system clock, and the block recognises START, repeated START and STOP conditions. It shifts in the address and data bytes MSB first and acknowledges the bytes meant for it. On a read it returns the contents of the selected register. SDA is never driven high: the block only asserts a pull-low enable for an external open-drain pad.

A write stores exactly one byte. The first data byte after the register pointer lands in the selected register. Any further bytes in the same transaction are acknowledged and then dropped, and the pointer does not advance. A read first sets the pointer with a write phase, then sends a repeated START (or STOP and START) with the read address, and receives one byte. The pointer is kept across STOP.

An interrupt source latches a one-cycle event input into a pending bit. The pending bit stays set until software clears it through the status register. The interrupt pin has a configurable active level. Its output enable stays off, leaving the pin floating, until the power-enable bit is set.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte of C0h (7-bit address 60h with the read/write flag in bit 0 clear) and of C1h (flag set, read).
- R2: The sequence START, C0h, pointer P, data D, STOP stores D into register P. The pointer byte and the data byte are both acknowledged.
- R3: Data bytes after the first one in a write transaction are acknowledged, but they change no register and do not advance the pointer.
- R4: After a pointer write, a repeated START followed by C1h makes the block send the contents of register P MSB first. The master NACKs the byte, and SDA is released after it.
- R5: The pointer survives a STOP. A read that begins with a fresh START after STOP returns register P.
- R6: An address byte other than C0h or C1h is not acknowledged. Every following byte is also ignored, unacknowledged, until the next START, and no register changes.
- R7: The SDA pull-low enable changes only while SCL is low.
- R8: Register map. Pointer 0 is the control register: bit 0 is power enable, bit 1 is polarity (1 = active high), and all 8 bits read back. Pointer 1 is the status register: bit 0 reads the pending flag, and writing a 1 to bit 0 clears it. Pointers 2 and 3 are plain storage. Pointers 4 and above read 00h, and writes to them are discarded.
- R9: The interrupt output enable follows the power-enable bit. While that bit is clear, the pin is released.
- R10: A pulse on the event input sets the pending flag. The flag holds until a status write with bit 0 set. The interrupt output sits at the active level while the flag is set and at the opposite level otherwise.
- R11: During and after reset, SDA and the interrupt pin are released and all registers read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullEn | output | 1 | 1 pulls SDA low; 0 releases it |
| irqEvent | input | 1 | One-cycle pulse that raises the interrupt |
| irqOut | output | 1 | Interrupt level at the selected polarity |
| irqOe | output | 1 | Output enable for the interrupt pad |

## Verification
The SDA timing check assumes the master holds SCL low for longer than the synchroniser delay plus one cycle, so that a change the target makes after a synchronised falling edge still falls inside the raw low phase. The bench keeps every SCL phase at five system clocks or more. The interrupt checks assume the event input and configuration writes never collide with a power or polarity change in the same cycle. The bench pulses the event line only between bus transactions. The master never issues START or STOP while the target is driving a read bit, so the target's release of SDA always happens while SCL is low.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef struct packed {
    logic shiftIn;
    logic ptrLoad;
    logic regWrite;
    logic txLoad;
    logic txShift;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h60,
  parameter int         SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t strobes,
  output logic      sdaBit,
  output logic      sdaPullEn
);

  localparam int BITS_PER_BYTE = 8;
  localparam logic [3:0] BYTE_DONE = 4'(BITS_PER_BYTE);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state;
  logic [3:0] bitCnt;
  logic isRead, firstData, ackDrive, masterAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  logic rxState, byteEnd, addrHit;
  assign rxState = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);
  assign byteEnd = sclFall && (bitCnt == BYTE_DONE);
  assign addrHit = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    strobes          = '0;
    strobes.shiftIn  = sclRise && rxState && (bitCnt < BYTE_DONE);
    strobes.ptrLoad  = byteEnd && (state == ST_PTR);
    strobes.regWrite = byteEnd && (state == ST_DATA) && firstData;
    strobes.txLoad   = sclFall && (((state == ST_ADDR_ACK) && isRead) ||
                                   ((state == ST_TX_ACK) && masterAck));
    strobes.txShift  = sclFall && (state == ST_TX) && (bitCnt != 4'd0) &&
                       (bitCnt < BYTE_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      firstData <= 1'b0;
      ackDrive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (sclRise && (bitCnt < BYTE_DONE)) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            if (state == ST_ADDR) begin
              if (addrHit) begin
                ackDrive <= 1'b1;
                isRead   <= rxByte[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              ackDrive <= 1'b1;
              state    <= ST_PTR_ACK;
            end else begin
              ackDrive  <= 1'b1;
              firstData <= 1'b0;
              state     <= ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_DATA_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_ADDR_ACK) begin
              state <= isRead ? ST_TX : ST_PTR;
            end else if (state == ST_PTR_ACK) begin
              firstData <= 1'b1;
              state     <= ST_DATA;
            end else begin
              state <= ST_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise && (bitCnt < BYTE_DONE)) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            bitCnt <= '0;
            state  <= ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullEn = ackDrive | ((state == ST_TX) & ~txMsb);

endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobes,
  input  logic      sdaBit,
  input  logic      irqEvent,
  output logic [7:0] rxByte,
  output logic      txMsb,
  output logic      irqOut,
  output logic      irqOe
);

  localparam int NUM_GP   = NUM_REGS - 2;
  localparam int GP_BASE  = 2;
  localparam logic [7:0] PTR_CTRL = 8'd0;
  localparam logic [7:0] PTR_STAT = 8'd1;

  logic [7:0] ptr;
  logic [7:0] txReg;
  logic [7:0] ctrlReg;
  logic       pending;
  logic [7:0] gpWord [NUM_GP];
  logic [NUM_GP-1:0] gpHit;
  logic [7:0] readData;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_hit
    assign gpHit[g] = (ptr == 8'(g + GP_BASE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptr    <= '0;
      txReg  <= '0;
    end else begin
      if (strobes.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (strobes.ptrLoad) ptr <= rxByte;
      if (strobes.txLoad) txReg <= readData;
      else if (strobes.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      for (int i = 0; i < NUM_GP; i++) gpWord[i] <= '0;
    end else if (strobes.regWrite) begin
      if (ptr == PTR_CTRL) ctrlReg <= rxByte;
      for (int i = 0; i < NUM_GP; i++) begin
        if (gpHit[i]) gpWord[i] <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (irqEvent) begin
      pending <= 1'b1;
    end else if (strobes.regWrite && (ptr == PTR_STAT) && rxByte[0]) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    readData = '0;
    if (ptr == PTR_CTRL) readData = ctrlReg;
    if (ptr == PTR_STAT) readData = {7'b0, pending};
    for (int i = 0; i < NUM_GP; i++) begin
      if (gpHit[i]) readData = gpWord[i];
    end
  end

  assign txMsb  = txReg[7];
  assign irqOe  = ctrlReg[0];
  assign irqOut = ~(pending ^ ctrlReg[1]);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h60,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullEn,
  input  logic irqEvent,
  output logic irqOut,
  output logic irqOe
);

  dpStrobe_t  ctrlStrobes;
  logic [7:0] rxByte;
  logic       txMsb;
  logic       sdaBit;

  i2c_reg_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .strobes  (ctrlStrobes),
    .sdaBit   (sdaBit),
    .sdaPullEn(sdaPullEn)
  );

  i2c_reg_dp #(
    .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (ctrlStrobes),
    .sdaBit  (sdaBit),
    .irqEvent(irqEvent),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .irqOut  (irqOut),
    .irqOe   (irqOe)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullEn,
  input logic irqEvent,
  input logic irqOut,
  input logic irqOe,
  input logic polHigh,
  input logic regWrite
);

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullEn) |-> !sclIn); // R7

  AST_IRQ_OE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqOe) |-> $past(regWrite)); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOe && $past(irqOe) && $stable(polHigh) && (irqOut == polHigh) &&
     ($past(irqOut) != polHigh)) |-> $past(irqEvent)); // R10

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (irqOe && $past(irqOe) && $stable(polHigh) && (irqOut != polHigh) &&
     ($past(irqOut) == polHigh)) |-> $past(regWrite)); // R10

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!sdaPullEn && !irqOe); // R11
    end
  end

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaPullEn(sdaPullEn),
  .irqEvent (irqEvent),
  .irqOut   (irqOut),
  .irqOe    (irqOe),
  .polHigh  (u_dp.ctrlReg[1]),
  .regWrite (ctrlStrobes.regWrite)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic mPull = 1'b0;
  logic irqEvent = 1'b0;
  logic sdaPullEn, irqOut, irqOe;
  logic sdaLine;
  int checks = 0;
  int fails = 0;
  int sclHighChanges = 0;
  bit done = 1'b0;
  logic prevPull = 1'b0;
  logic [7:0] model [6];

  always #2.5 clk = ~clk;

  assign sdaLine = !(mPull || sdaPullEn);

  i2c_reg_target i_i2c_reg_target (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclLine),
    .sdaIn    (sdaLine),
    .sdaPullEn(sdaPullEn),
    .irqEvent (irqEvent),
    .irqOut   (irqOut),
    .irqOe    (irqOe)
  );

  always @(negedge clk) begin
    if (rstN && (sdaPullEn !== prevPull) && sclLine) sclHighChanges++;
    prevPull <= sdaPullEn;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sclLine = 1'b0; waitQ();
    mPull = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    mPull = 1'b1; waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sclLine = 1'b0; waitQ();
    mPull = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    mPull = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mPull = !b[i]; waitQ();
      sclLine = 1'b1; waitQ(2);
      sclLine = 1'b0; waitQ();
    end
    mPull = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    acked = !sdaLine;
    waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    mPull = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ();
      sclLine = 1'b1; waitQ();
      b = {b[6:0], sdaLine};
      waitQ();
      sclLine = 1'b0; waitQ();
    end
    mPull = giveAck; waitQ();
    sclLine = 1'b1; waitQ(2);
    sclLine = 1'b0; waitQ();
    mPull = 1'b0;
  endtask

  task automatic regWr(input logic [7:0] ptr, input logic [7:0] d, input int extra,
                       output bit allAck);
    bit a;
    allAck = 1'b1;
    startCond();
    writeByte(8'hC0, a); allAck &= a;
    writeByte(ptr, a);   allAck &= a;
    writeByte(d, a);     allAck &= a;
    for (int i = 0; i < extra; i++) begin
      writeByte(d ^ 8'(8'h5A + i), a); allAck &= a;
    end
    stopCond();
  endtask

  task automatic regRd(input logic [7:0] ptr, input bit viaStop, output logic [7:0] d,
                       output bit allAck);
    bit a;
    allAck = 1'b1;
    startCond();
    writeByte(8'hC0, a); allAck &= a;
    writeByte(ptr, a);   allAck &= a;
    if (viaStop) stopCond();
    startCond();
    writeByte(8'hC1, a); allAck &= a;
    readByte(1'b0, d);
    stopCond();
  endtask

  task automatic pulseEvent();
    @(posedge clk); #1 irqEvent = 1'b1;
    @(posedge clk); #1 irqEvent = 1'b0;
    waitQ();
  endtask

  function automatic logic [7:0] expRead(input int p);
    if (p >= 2 && p <= 3) return model[p];
    return 8'h00;
  endfunction

  initial begin
    logic [7:0] d;
    bit ok;
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h3C};
    for (int i = 0; i < 6; i++) model[i] = 8'h00;
    waitQ(2);
    check(sdaPullEn == 1'b0 && irqOe == 1'b0, "R11 reset pins", {sdaPullEn, irqOe}, 0);
    rstN = 1'b1;
    waitQ(2);
    for (int p = 0; p < 4; p++) begin
      regRd(8'(p), 1'b0, d, ok);
      check(d == 8'h00, "R11 reset register", d, 0);
      check(ok, "R1 address acks", ok, 1);
    end
    check(sdaPullEn == 1'b0, "R4 SDA released after read", sdaPullEn, 0);

    // R2 R4 R8: sweep pointers 2..5 with several patterns
    for (int p = 2; p < 6; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] v;
        v = pats[k] ^ 8'(p * 17);
        regWr(8'(p), v, 0, ok);
        check(ok, "R2 write acks", ok, 1);
        if (p <= 3) model[p] = v;
        regRd(8'(p), 1'b0, d, ok);
        check(d == expRead(p), "R4 R8 read back", d, expRead(p));
      end
    end

    // R3: extra bytes ignored
    regWr(8'd2, 8'hC3, 3, ok);
    check(ok, "R3 extra bytes acked", ok, 1);
    model[2] = 8'hC3;
    regRd(8'd2, 1'b0, d, ok);
    check(d == 8'hC3, "R3 first byte kept", d, 8'hC3);
    regRd(8'd3, 1'b0, d, ok);
    check(d == model[3], "R3 neighbour untouched", d, model[3]);

    // R5: pointer kept over STOP
    regWr(8'd3, 8'h96, 0, ok);
    model[3] = 8'h96;
    regRd(8'd3, 1'b1, d, ok);
    check(d == 8'h96 && ok, "R5 read after stop", d, 8'h96);

    // R6: foreign addresses
    for (int a = 0; a < 128; a++) begin
      bit acked;
      if (a == 8'h60) continue;
      startCond();
      writeByte({7'(a), 1'b0}, acked);
      check(!acked, "R6 foreign address nack", acked, 0);
      writeByte(8'd2, acked);
      check(!acked, "R6 ignored byte nack", acked, 0);
      stopCond();
    end
    regRd(8'd2, 1'b0, d, ok);
    check(d == model[2], "R6 register unchanged", d, model[2]);

    // R8 R9 R10: interrupt
    pulseEvent();
    check(irqOe == 1'b0, "R9 pin released while power off", irqOe, 0);
    regRd(8'd1, 1'b0, d, ok);
    check(d == 8'h01, "R8 R10 status pending", d, 1);
    regWr(8'd0, 8'h01, 0, ok);
    check(irqOe == 1'b1, "R9 power enable", irqOe, 1);
    check(irqOut == 1'b0, "R10 active low asserted", irqOut, 0);
    regWr(8'd1, 8'h01, 0, ok);
    check(irqOut == 1'b1, "R10 cleared active low", irqOut, 1);
    pulseEvent();
    check(irqOut == 1'b0, "R10 event raises", irqOut, 0);
    regWr(8'd0, 8'h03, 0, ok);
    check(irqOut == 1'b1, "R10 active high asserted", irqOut, 1);
    regWr(8'd1, 8'h00, 0, ok);
    check(irqOut == 1'b1, "R10 zero write keeps pending", irqOut, 1);
    regWr(8'd1, 8'h01, 0, ok);
    check(irqOut == 1'b0, "R10 cleared active high", irqOut, 0);
    regRd(8'd0, 1'b0, d, ok);
    check(d == 8'h03, "R8 control readback", d, 3);
    regWr(8'd0, 8'h00, 0, ok);
    check(irqOe == 1'b0, "R9 power off releases", irqOe, 0);

    check(sclHighChanges == 0, "R7 SDA changes with SCL low", sclHighChanges, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule